// File: doc/BRIEF.md
# Versioned Page Mapping Table Updater

This block holds a direct-mapped page translation table in which no mapping is ever overwritten in place. The table is split in two. The low region has one slot per virtual page, and the page number is that slot's index. The high region cannot be reached through a page number. When a page gets a new physical location, the entry in the page's slot is first copied into a free high slot. The new mapping is then written into the page's slot, and its back pointer is set to that copy. Each page therefore heads a singly linked chain of its older mappings.

There are three ports. The lookup port returns the head entry of a page. The walk port returns any slot by its index, so a caller can follow the back pointers one step at a time. The update port installs a new mapping. It takes the new location, a sub-page valid vector and a status byte. The write time is stamped from an internal free-running counter. High slots are handed out from a free pointer, and an update that finds no free slot is refused.

Top module: `vpt_updater`

## Requirements
- R1: After reset, every page slot holds location 0, valid vector 0, time 0, status 0 and a back pointer equal to the end marker. `up_busy`, `up_done` and `up_err` are low.
- R2: One cycle after `lk_req`, `lk_valid` is high and `lk_entry` holds the slot of `lk_vpn` as it stood at the request edge.
- R3: An accepted update raises `up_busy` for exactly two cycles. `up_done` is then high for one cycle.
- R4: After an update, the page slot holds the new location, valid vector and status. Its time field holds the counter value at the accepting edge. The counter starts at 0 and counts every clock after reset. The back pointer holds the high slot just allocated. The entry is packed, from most significant bit down, as location (34), back pointer (VPN_W+2), valid vector (32), time (24), status (8).
- R5: The allocated high slot holds an exact copy of the former head, including the former head's back pointer.
- R6: High slots are allocated in ascending order, starting at 2^VPN_W. One cycle after `cw_req`, `cw_valid` is high and `cw_entry` holds slot `cw_idx`.
- R7: When no high slot is left, an update request pulses `up_err` for one cycle. No busy period follows and the table is unchanged.
- R8: An `up_req` asserted while `up_busy` is high is ignored.
- R9: The end marker is the all-ones index (2^(VPN_W+2)-1). Walking to it returns an all-zero entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_entry | output | ENT_W | Head entry of the page |
| cw_req | input | 1 | Walk request |
| cw_idx | input | VPN_W+2 | Slot to read |
| cw_valid | output | 1 | Walk result valid |
| cw_entry | output | ENT_W | Entry read from the slot |
| up_req | input | 1 | Update request |
| up_vpn | input | VPN_W | Page being remapped |
| up_loc | input | LOC_W | New physical location |
| up_vec | input | VEC_W | New sub-page valid vector |
| up_stat | input | ST_W | New status and permission byte |
| up_busy | output | 1 | Update in progress |
| up_done | output | 1 | Update finished |
| up_err | output | 1 | Update refused, no free slot |

## Verification
The hardest state to reach is an exhausted free region. Every high slot must first be consumed by real updates, and only then does the refusal path run. The stimulus therefore sends one accepted update per free slot, spread over different pages so that some chains grow several links deep. It then sends one more request and walks the chains to confirm that nothing moved. Requests issued during the busy window, and lookups issued in the same cycle as the final write, are placed deliberately to expose any ordering slip.

// File: rtl/vpt_updater.sv
module vpt_updater #(
  parameter int VPN_W  = 4,
  parameter int LOC_W  = 34,
  parameter int VEC_W  = 32,
  parameter int TIME_W = 24,
  parameter int ST_W   = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        lk_req,
  input  logic [VPN_W-1:0]                            lk_vpn,
  output logic                                        lk_valid,
  output logic [LOC_W+VPN_W+2+VEC_W+TIME_W+ST_W-1:0]  lk_entry,
  input  logic                                        cw_req,
  input  logic [VPN_W+1:0]                            cw_idx,
  output logic                                        cw_valid,
  output logic [LOC_W+VPN_W+2+VEC_W+TIME_W+ST_W-1:0]  cw_entry,
  input  logic                                        up_req,
  input  logic [VPN_W-1:0]                            up_vpn,
  input  logic [LOC_W-1:0]                            up_loc,
  input  logic [VEC_W-1:0]                            up_vec,
  input  logic [ST_W-1:0]                             up_stat,
  output logic                                        up_busy,
  output logic                                        up_done,
  output logic                                        up_err
);
  localparam int IDX_W = VPN_W + 2;
  localparam int ENT_W = LOC_W + IDX_W + VEC_W + TIME_W + ST_W;
  localparam int NSLOT = (1 << IDX_W) - 1;
  localparam int NPAGE = 1 << VPN_W;
  localparam logic [IDX_W-1:0] NIL = '1;
  localparam logic [ENT_W-1:0] HEAD0 =
    {{LOC_W{1'b0}}, NIL, {(VEC_W+TIME_W+ST_W){1'b0}}};

  typedef enum logic [1:0] {IDLE, MOVE, PUT} ph_t;

  logic [ENT_W-1:0]  mem [NSLOT];
  ph_t               ph;
  logic [IDX_W-1:0]  free_nx;
  logic [TIME_W-1:0] tick, stamp;
  logic [ENT_W-1:0]  copy_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [LOC_W-1:0]  loc_q;
  logic [VEC_W-1:0]  vec_q;
  logic [ST_W-1:0]   st_q;

  wire idle_req = up_req && (ph == IDLE);
  wire is_full  = (free_nx == NIL);

  assign up_busy = (ph != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++)
        mem[i] <= (i < NPAGE) ? HEAD0 : '0;
    end else if (ph == MOVE) begin
      mem[free_nx] <= copy_q;
    end else if (ph == PUT) begin
      mem[{2'b00, vpn_q}] <= {loc_q, free_nx, vec_q, stamp, st_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= IDLE;
      free_nx  <= IDX_W'(NPAGE);
      tick     <= '0;
      up_done  <= 1'b0;
      up_err   <= 1'b0;
      lk_valid <= 1'b0;
      cw_valid <= 1'b0;
      lk_entry <= '0;
      cw_entry <= '0;
      copy_q   <= '0;
      vpn_q    <= '0;
      loc_q    <= '0;
      vec_q    <= '0;
      st_q     <= '0;
      stamp    <= '0;
    end else begin
      tick     <= tick + 1'b1;
      up_done  <= 1'b0;
      up_err   <= idle_req && is_full;
      lk_valid <= lk_req;
      cw_valid <= cw_req;
      if (lk_req) lk_entry <= mem[{2'b00, lk_vpn}];
      if (cw_req) cw_entry <= (cw_idx == NIL) ? '0 : mem[cw_idx];
      case (ph)
        IDLE: if (idle_req && !is_full) begin
          copy_q <= mem[{2'b00, up_vpn}];
          vpn_q  <= up_vpn;
          loc_q  <= up_loc;
          vec_q  <= up_vec;
          st_q   <= up_stat;
          stamp  <= tick;
          ph     <= MOVE;
        end
        MOVE: ph <= PUT;
        default: begin
          free_nx <= free_nx + 1'b1;
          up_done <= 1'b1;
          ph      <= IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/vpt_updater_chk.sv
module vpt_updater_chk (
  input logic clk,
  input logic rst_n,
  input logic up_req,
  input logic up_busy,
  input logic up_done,
  input logic up_err,
  input logic lk_req,
  input logic lk_valid,
  input logic cw_req,
  input logic cw_valid
);
  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_busy) |=> up_busy);
  assert_busy_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_busy && $past(up_busy)) |=> !up_busy);
  assert_done_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_busy) |-> up_done);
  assert_done_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |=> !up_done);
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_err |-> (!up_busy && !up_done));
  assert_lk_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid);
  assert_cw_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cw_req |=> cw_valid);
endmodule

bind vpt_updater vpt_updater_chk i_chk (.*);

// File: tb/test_vpt_updater.sv
`timescale 1ns/1ps
module test_vpt_updater;
  localparam int VPN_W = 4, LOC_W = 34, VEC_W = 32, TIME_W = 24, ST_W = 8;
  localparam int IDX_W = VPN_W + 2;
  localparam int ENT_W = LOC_W + IDX_W + VEC_W + TIME_W + ST_W;
  localparam int NIL = (1 << IDX_W) - 1;
  localparam int NPAGE = 1 << VPN_W;

  logic clk = 0, rst_n = 0;
  logic lk_req = 0, cw_req = 0, up_req = 0;
  logic [VPN_W-1:0] lk_vpn = '0, up_vpn = '0;
  logic [IDX_W-1:0] cw_idx = '0;
  logic [LOC_W-1:0] up_loc = '0;
  logic [VEC_W-1:0] up_vec = '0;
  logic [ST_W-1:0]  up_stat = '0;
  logic lk_valid, cw_valid, up_busy, up_done, up_err;
  logic [ENT_W-1:0] lk_entry, cw_entry;

  vpt_updater i_vpt_updater (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit finished = 0;

  logic [ENT_W-1:0] m_mem [NIL+1];
  int m_phase, m_free, m_tick, m_vpn, m_stamp;
  logic [ENT_W-1:0] m_copy, e_lk, e_cw;
  logic [LOC_W-1:0] m_loc; logic [VEC_W-1:0] m_vec; logic [ST_W-1:0] m_st;
  logic e_lkv, e_cwv, e_busy, e_done, e_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NIL; i++)
        m_mem[i] = (i < NPAGE) ? {{LOC_W{1'b0}}, IDX_W'(NIL), {(VEC_W+TIME_W+ST_W){1'b0}}} : '0;
      m_phase = 0; m_free = NPAGE; m_tick = 0;
      e_lkv = 0; e_cwv = 0; e_lk = '0; e_cw = '0;
      e_busy = 0; e_done = 0; e_err = 0;
    end else begin
      e_lkv = lk_req; e_cwv = cw_req;
      if (lk_req) e_lk = m_mem[lk_vpn];
      if (cw_req) e_cw = m_mem[cw_idx];
      e_done = 0; e_err = 0;
      if (m_phase == 0) begin
        if (up_req) begin
          if (m_free == NIL) e_err = 1;
          else begin
            m_copy = m_mem[up_vpn]; m_vpn = up_vpn; m_loc = up_loc;
            m_vec = up_vec; m_st = up_stat; m_stamp = m_tick; m_phase = 1;
          end
        end
      end else if (m_phase == 1) begin
        m_mem[m_free] = m_copy; m_phase = 2;
      end else begin
        m_mem[m_vpn] = {m_loc, IDX_W'(m_free), m_vec, TIME_W'(m_stamp), m_st};
        m_free++; e_done = 1; m_phase = 0;
      end
      e_busy = (m_phase != 0);
      m_tick++;
    end
  end

  task automatic chk(string req, logic [ENT_W-1:0] act, logic [ENT_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R3 busy", ENT_W'(up_busy), ENT_W'(e_busy));
    chk("R3 done", ENT_W'(up_done), ENT_W'(e_done));
    chk("R7 err", ENT_W'(up_err), ENT_W'(e_err));
    chk("R2 lk_valid", ENT_W'(lk_valid), ENT_W'(e_lkv));
    chk("R6 cw_valid", ENT_W'(cw_valid), ENT_W'(e_cwv));
    chk({tag, " lk_entry"}, lk_entry, e_lk);
    chk({tag, " R5 cw_entry"}, cw_entry, e_cw);
  end

  task automatic look(int v);
    @(negedge clk); lk_req = 1; lk_vpn = VPN_W'(v);
    @(negedge clk); lk_req = 0;
  endtask

  task automatic walk(int i);
    @(negedge clk); cw_req = 1; cw_idx = IDX_W'(i);
    @(negedge clk); cw_req = 0;
  endtask

  task automatic upd(int v, logic [LOC_W-1:0] loc, logic [VEC_W-1:0] vec, logic [ST_W-1:0] st);
    @(negedge clk); up_req = 1; up_vpn = VPN_W'(v); up_loc = loc; up_vec = vec; up_stat = st;
    @(negedge clk); up_req = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; look(0); look(NPAGE-1);
    tag = "R9"; walk(NIL); walk(NPAGE);
    tag = "R4";
    upd(3, 34'h2_1234_5678, 32'h0000_FFFF, 8'hA5);
    look(3);
    upd(3, 34'h3_0000_0001, 32'hFFFF_0000, 8'h11);
    upd(3, 34'h1_AAAA_5555, 32'h8000_0001, 8'h7E);
    look(3);
    tag = "R5"; walk(NPAGE); walk(NPAGE+1); walk(NPAGE+2);
    tag = "R8";
    @(negedge clk); up_req = 1; up_vpn = 7; up_loc = 34'h0_0000_0777; up_vec = '1; up_stat = 8'h01;
    @(negedge clk); up_vpn = 8; up_loc = 34'h0_0000_0888;
    @(negedge clk); up_req = 0;
    @(negedge clk); lk_req = 1; lk_vpn = 7;
    @(negedge clk); lk_req = 0;
    look(8); look(7);
    tag = "R6";
    for (int k = 0; k < 60; k++) begin
      if (k == 43) tag = "R7";
      upd(k % NPAGE, LOC_W'(k * 32'h0101_0103), VEC_W'(32'h1 << (k % 32)), ST_W'(k));
    end
    for (int p = 0; p < NPAGE; p++) look(p);
    for (int s = NPAGE; s <= NIL; s++) walk(s);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1; mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule